// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Ownership Lock

This block lets several Wishbone initiator ports share one initiator-side Wishbone bus. One initiator at a time owns the shared bus. Its address, write data, byte selects, write enable, cyc, stb and lock are passed straight through. The target's ack, err and rty go back only to that owner. Read data is broadcast to every port, and a port that is not the owner sees no handshake.

Ownership is a registered index. It is re-evaluated in two situations: at the end of a transaction (the owner's cyc and stb are high and the target answers with ack, err or rty), or whenever the owner's cyc is low. A held cyc does not keep the bus. An owner that keeps cyc high after a completed transaction can lose the bus to another requester, unless it also asserts lock.

Selection searches in round-robin order, starting at the index after the current owner. Initiators may use a select granularity coarser than the shared bus. Each of their select bits is replicated to cover the finer lanes of the shared bus.

Top module: `wbarb_top`

## Requirements
- R1: After reset, initiator 0 owns the shared bus.
- R2: The shared bus adr, dat_w, we, cyc, stb and lock equal those of the current owner in the same cycle.
- R3: Shared select bit b equals the owner's select bit b / REP, where REP = INIT_GRAN / BUS_GRAN (with the defaults, owner bit 0 drives shared bits 0 and 1, and owner bit 1 drives shared bits 2 and 3).
- R4: Only the owner's port carries ack, err and rty, copied from the shared bus. Every other port reads them as 0. Shared dat_r appears on the common read-data output.
- R5: On re-arbitration, the new owner is the first initiator with cyc high, searched from owner+1 upward modulo N_INIT. The current owner is tried last.
- R6: Re-arbitration happens only after a cycle in which the owner's cyc is low, or after a cycle in which cyc, stb and a response (ack, err or rty) are all high while lock is low. It then holds even if the owner keeps cyc high. At all other times ownership stays unchanged.
- R7: While the owner holds cyc and lock high, ownership is kept across completed transactions.
- R8: With no initiator asserting cyc, the last owner index is retained and shared cyc is low.
- R9: A change of owner takes effect at the clock edge after the deciding cycle. In a completion cycle, the shared bus still shows the old owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_adr_i | input | N_INIT*ADDR_W | Initiator addresses, port i at [i*ADDR_W +: ADDR_W] |
| init_dat_w_i | input | N_INIT*DATA_W | Initiator write data |
| init_sel_i | input | N_INIT*ISEL_W | Initiator byte-lane selects, ISEL_W = DATA_W/INIT_GRAN |
| init_we_i | input | N_INIT | Initiator write enables |
| init_cyc_i | input | N_INIT | Initiator cycle requests |
| init_stb_i | input | N_INIT | Initiator strobes |
| init_lock_i | input | N_INIT | Initiator ownership locks |
| init_dat_r_o | output | DATA_W | Read data, common to all ports |
| init_ack_o | output | N_INIT | Per-port ack |
| init_err_o | output | N_INIT | Per-port err |
| init_rty_o | output | N_INIT | Per-port rty |
| bus_adr_o | output | ADDR_W | Shared address |
| bus_dat_w_o | output | DATA_W | Shared write data |
| bus_sel_o | output | BSEL_W | Shared selects, BSEL_W = DATA_W/BUS_GRAN |
| bus_we_o | output | 1 | Shared write enable |
| bus_cyc_o | output | 1 | Shared cycle |
| bus_stb_o | output | 1 | Shared strobe |
| bus_lock_o | output | 1 | Shared lock |
| bus_dat_r_i | input | DATA_W | Shared read data |
| bus_ack_i | input | 1 | Shared ack |
| bus_err_i | input | 1 | Shared err |
| bus_rty_i | input | 1 | Shared rty |

## Verification
Several properties are checked on every cycle. Handshakes reach a port only when the shared bus carries them, and at most one port sees ack. Ownership never moves while a locked owner holds cyc, never moves in the middle of an unanswered transaction, and never moves while the bus is idle. The owner index also stays in range. Other behaviour needs the bench's reference model and directed sequences: the round-robin order and its wrap, the loss of the bus by an unlocked owner that holds cyc, the reset owner, and the one-edge delay of a handover.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;

  typedef struct packed {
    logic ack;
    logic err;
    logic rty;
  } wb_rsp_t;

  function automatic int unsigned wrap_add(int unsigned base, int unsigned off, int unsigned n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/wbarb_rr_pick.sv
module wbarb_rr_pick
  import wbarb_pkg::*;
#(
  parameter int unsigned N_REQ = 3,
  parameter int unsigned GW    = 2
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic [GW-1:0]    last_i,
  output logic [GW-1:0]    pick_o,
  output logic             found_o
);

  // search last+1 .. last+N, so the previous owner is tried last
  always_comb begin
    pick_o  = last_i;
    found_o = 1'b0;
    for (int unsigned off = 1; off <= N_REQ; off++) begin
      int unsigned idx;
      idx = wrap_add(int'(last_i), off, N_REQ);
      if (!found_o && req_i[idx]) begin
        found_o = 1'b1;
        pick_o  = GW'(idx);
      end
    end
  end

endmodule

// File: rtl/wbarb_sel_widen.sv
module wbarb_sel_widen #(
  parameter int unsigned IN_W  = 2,
  parameter int unsigned OUT_W = 4
) (
  input  logic [IN_W-1:0]  sel_i,
  output logic [OUT_W-1:0] sel_o
);

  localparam int unsigned REP = OUT_W / IN_W;

  for (genvar b = 0; b < OUT_W; b++) begin : g_lane
    assign sel_o[b] = sel_i[b / REP];
  end

endmodule

// File: rtl/wbarb_top.sv
module wbarb_top
  import wbarb_pkg::*;
#(
  parameter int unsigned N_INIT    = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUS_GRAN  = 8,
  parameter int unsigned INIT_GRAN = 16,
  localparam int unsigned BSEL_W   = DATA_W / BUS_GRAN,
  localparam int unsigned ISEL_W   = DATA_W / INIT_GRAN
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_INIT*ADDR_W-1:0]   init_adr_i,
  input  logic [N_INIT*DATA_W-1:0]   init_dat_w_i,
  input  logic [N_INIT*ISEL_W-1:0]   init_sel_i,
  input  logic [N_INIT-1:0]          init_we_i,
  input  logic [N_INIT-1:0]          init_cyc_i,
  input  logic [N_INIT-1:0]          init_stb_i,
  input  logic [N_INIT-1:0]          init_lock_i,
  output logic [DATA_W-1:0]          init_dat_r_o,
  output logic [N_INIT-1:0]          init_ack_o,
  output logic [N_INIT-1:0]          init_err_o,
  output logic [N_INIT-1:0]          init_rty_o,
  output logic [ADDR_W-1:0]          bus_adr_o,
  output logic [DATA_W-1:0]          bus_dat_w_o,
  output logic [BSEL_W-1:0]          bus_sel_o,
  output logic                       bus_we_o,
  output logic                       bus_cyc_o,
  output logic                       bus_stb_o,
  output logic                       bus_lock_o,
  input  logic [DATA_W-1:0]          bus_dat_r_i,
  input  logic                       bus_ack_i,
  input  logic                       bus_err_i,
  input  logic                       bus_rty_i
);

  localparam int unsigned GW = (N_INIT > 1) ? $clog2(N_INIT) : 1;

  logic [ADDR_W-1:0] adr_a [N_INIT];
  logic [DATA_W-1:0] dat_a [N_INIT];
  logic [ISEL_W-1:0] sel_a [N_INIT];

  for (genvar i = 0; i < N_INIT; i++) begin : g_unpack
    assign adr_a[i] = init_adr_i[i*ADDR_W +: ADDR_W];
    assign dat_a[i] = init_dat_w_i[i*DATA_W +: DATA_W];
    assign sel_a[i] = init_sel_i[i*ISEL_W +: ISEL_W];
  end

  logic [GW-1:0] grant_q;
  logic [GW-1:0] pick;
  logic          found;
  logic          own_cyc, own_stb, own_lock;
  logic          xfer_done, rearb;
  logic [ISEL_W-1:0] own_sel;

  assign own_cyc  = init_cyc_i[grant_q];
  assign own_stb  = init_stb_i[grant_q];
  assign own_lock = init_lock_i[grant_q];
  assign own_sel  = sel_a[grant_q];

  assign xfer_done = own_cyc & own_stb & (bus_ack_i | bus_err_i | bus_rty_i);
  // cyc alone never holds the bus; only lock does
  assign rearb     = ~own_cyc | (xfer_done & ~own_lock);

  wbarb_rr_pick #(
    .N_REQ (N_INIT),
    .GW    (GW)
  ) u_pick (
    .req_i   (init_cyc_i),
    .last_i  (grant_q),
    .pick_o  (pick),
    .found_o (found)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             grant_q <= '0;
    else if (rearb && found) grant_q <= pick;
  end

  // forward path
  assign bus_adr_o   = adr_a[grant_q];
  assign bus_dat_w_o = dat_a[grant_q];
  assign bus_we_o    = init_we_i[grant_q];
  assign bus_cyc_o   = own_cyc;
  assign bus_stb_o   = own_stb;
  assign bus_lock_o  = own_lock;

  if (BSEL_W == ISEL_W) begin : g_sel_same
    assign bus_sel_o = own_sel;
  end else begin : g_sel_wide
    wbarb_sel_widen #(
      .IN_W  (ISEL_W),
      .OUT_W (BSEL_W)
    ) u_widen (
      .sel_i (own_sel),
      .sel_o (bus_sel_o)
    );
  end

  // response path
  wb_rsp_t bus_rsp;
  assign bus_rsp      = '{ack: bus_ack_i, err: bus_err_i, rty: bus_rty_i};
  assign init_dat_r_o = bus_dat_r_i;

  for (genvar i = 0; i < N_INIT; i++) begin : g_rsp
    wb_rsp_t port_rsp;
    assign port_rsp      = (grant_q == GW'(i)) ? bus_rsp : '0;
    assign init_ack_o[i] = port_rsp.ack;
    assign init_err_o[i] = port_rsp.err;
    assign init_rty_o[i] = port_rsp.rty;
  end

endmodule

// File: rtl/wbarb_chk.sv
module wbarb_chk #(
  parameter int unsigned N_INIT = 3,
  parameter int unsigned GW     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_INIT-1:0] init_cyc_i,
  input logic [N_INIT-1:0] init_ack_o,
  input logic [N_INIT-1:0] init_err_o,
  input logic [N_INIT-1:0] init_rty_o,
  input logic              bus_cyc_o,
  input logic              bus_stb_o,
  input logic              bus_lock_o,
  input logic              bus_ack_i,
  input logic              bus_err_i,
  input logic              bus_rty_i,
  input logic [GW-1:0]     grant_q
);

  a_r4_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(init_ack_o));

  a_r4_ack_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|init_ack_o) |-> bus_ack_i);

  a_r4_err_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|init_err_o) |-> bus_err_i);

  a_r4_rty_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|init_rty_o) |-> bus_rty_i);

  a_r6_hold_open_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && !(bus_stb_o && (bus_ack_i || bus_err_i || bus_rty_i))) |=> $stable(grant_q));

  a_r7_lock_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_lock_o) |=> $stable(grant_q));

  a_r8_idle_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_cyc_i == '0) |=> $stable(grant_q));

  a_r5_grant_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(grant_q) < N_INIT);

endmodule

bind wbarb_top wbarb_chk #(
  .N_INIT (N_INIT),
  .GW     (GW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_cyc_i (init_cyc_i),
  .init_ack_o (init_ack_o),
  .init_err_o (init_err_o),
  .init_rty_o (init_rty_o),
  .bus_cyc_o  (bus_cyc_o),
  .bus_stb_o  (bus_stb_o),
  .bus_lock_o (bus_lock_o),
  .bus_ack_i  (bus_ack_i),
  .bus_err_i  (bus_err_i),
  .bus_rty_i  (bus_rty_i),
  .grant_q    (grant_q)
);

// File: tb/wbarb_top_tb.sv
`timescale 1ns/1ps
module wbarb_top_tb;
  localparam int N = 3, AW = 16, DW = 32, BG = 8, IG = 16;
  localparam int BS = DW / BG, IS = DW / IG, REP = IG / BG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N*AW-1:0] init_adr;
  logic [N*DW-1:0] init_dat_w;
  logic [N*IS-1:0] init_sel;
  logic [N-1:0]    init_we, init_cyc, init_stb, init_lock;
  logic [DW-1:0]   init_dat_r;
  logic [N-1:0]    init_ack, init_err, init_rty;
  logic [AW-1:0]   bus_adr;
  logic [DW-1:0]   bus_dat_w, bus_dat_r;
  logic [BS-1:0]   bus_sel;
  logic            bus_we, bus_cyc, bus_stb, bus_lock;
  logic            bus_ack, bus_err, bus_rty;

  wbarb_top #(.N_INIT(N), .ADDR_W(AW), .DATA_W(DW), .BUS_GRAN(BG), .INIT_GRAN(IG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .init_adr_i(init_adr), .init_dat_w_i(init_dat_w), .init_sel_i(init_sel),
    .init_we_i(init_we), .init_cyc_i(init_cyc), .init_stb_i(init_stb), .init_lock_i(init_lock),
    .init_dat_r_o(init_dat_r), .init_ack_o(init_ack), .init_err_o(init_err), .init_rty_o(init_rty),
    .bus_adr_o(bus_adr), .bus_dat_w_o(bus_dat_w), .bus_sel_o(bus_sel), .bus_we_o(bus_we),
    .bus_cyc_o(bus_cyc), .bus_stb_o(bus_stb), .bus_lock_o(bus_lock),
    .bus_dat_r_i(bus_dat_r), .bus_ack_i(bus_ack), .bus_err_i(bus_err), .bus_rty_i(bus_rty)
  );

  int errs = 0, checks = 0, mdl_g = 0;
  bit fin = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BS-1:0] widen(logic [IS-1:0] s);
    logic [BS-1:0] r;
    for (int b = 0; b < BS; b++) r[b] = s[b / REP];
    return r;
  endfunction

  function automatic int next_grant(int g);
    bit rearb;
    rearb = !init_cyc[g] ||
            (init_stb[g] && (bus_ack || bus_err || bus_rty) && !init_lock[g]);
    if (!rearb) return g;
    for (int off = 1; off <= N; off++) begin
      int idx = (g + off) % N;
      if (init_cyc[idx]) return idx;
    end
    return g;
  endfunction

  task automatic compare();
    int g = mdl_g;
    chk(bus_adr == init_adr[g*AW +: AW], "R2", "adr", 64'(bus_adr), 64'(init_adr[g*AW +: AW]));
    chk(bus_dat_w == init_dat_w[g*DW +: DW], "R2", "dat_w", 64'(bus_dat_w), 64'(init_dat_w[g*DW +: DW]));
    chk(bus_we == init_we[g], "R2", "we", 64'(bus_we), 64'(init_we[g]));
    chk(bus_cyc == init_cyc[g], "R2", "cyc", 64'(bus_cyc), 64'(init_cyc[g]));
    chk(bus_stb == init_stb[g], "R2", "stb", 64'(bus_stb), 64'(init_stb[g]));
    chk(bus_lock == init_lock[g], "R2", "lock", 64'(bus_lock), 64'(init_lock[g]));
    chk(bus_sel == widen(init_sel[g*IS +: IS]), "R3", "sel", 64'(bus_sel), 64'(widen(init_sel[g*IS +: IS])));
    chk(init_dat_r == bus_dat_r, "R4", "dat_r", 64'(init_dat_r), 64'(bus_dat_r));
    for (int i = 0; i < N; i++) begin
      logic ea, ee, er;
      ea = (i == g) && bus_ack;
      ee = (i == g) && bus_err;
      er = (i == g) && bus_rty;
      chk(init_ack[i] == ea, "R4", $sformatf("ack[%0d]", i), 64'(init_ack[i]), 64'(ea));
      chk(init_err[i] == ee, "R4", $sformatf("err[%0d]", i), 64'(init_err[i]), 64'(ee));
      chk(init_rty[i] == er, "R4", $sformatf("rty[%0d]", i), 64'(init_rty[i]), 64'(er));
    end
  endtask

  // called just after a falling edge with inputs settled
  task automatic step();
    int nxt;
    #1;
    compare();
    nxt = next_grant(mdl_g);
    @(posedge clk);
    mdl_g = nxt;
    @(negedge clk);
  endtask

  task automatic chk_owner(int exp, string req);
    #1;
    chk(bus_adr == AW'(16'h1000 * (exp + 1)), req, "owner adr", 64'(bus_adr), 64'(16'h1000 * (exp + 1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errs++; checks++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    init_dat_w = '0; init_sel = '0; init_we = '0;
    init_cyc = '0; init_stb = '0; init_lock = '0;
    bus_dat_r = 32'hA5A5_0001; bus_ack = 0; bus_err = 0; bus_rty = 0;
    for (int i = 0; i < N; i++) begin
      init_adr[i*AW +: AW] = AW'(16'h1000 * (i + 1));
      init_sel[i*IS +: IS] = IS'(i + 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset owner is initiator 0; R8 idle bus cyc low
    chk_owner(0, "R1");
    chk(bus_cyc == 1'b0, "R8", "idle cyc", 64'(bus_cyc), 64'd0);
    step();
    // R5: owner 0 idle, inits 1 and 2 request -> 1 first
    init_cyc = 3'b110;
    step();
    chk_owner(1, "R5");
    // R9: completion cycle still shows old owner
    init_stb[1] = 1; bus_ack = 1;
    chk_owner(1, "R9");
    step();
    // R6: cyc held without lock loses the bus
    bus_ack = 0; init_stb[1] = 0;
    chk_owner(2, "R6");
    // R7: lock keeps ownership across completions
    init_lock[2] = 1; init_stb[2] = 1; bus_ack = 1;
    step();
    chk_owner(2, "R7");
    step();
    chk_owner(2, "R7");
    // unlock, complete: search wraps past 0 (idle) to 1
    init_lock[2] = 0;
    step();
    bus_ack = 0; init_stb = '0;
    chk_owner(1, "R5");
    // R8: nobody requests -> owner index retained, cyc low
    init_cyc = '0;
    step();
    chk_owner(1, "R8");
    chk(bus_cyc == 1'b0, "R8", "idle cyc", 64'(bus_cyc), 64'd0);
    step();
    chk_owner(1, "R8");
    // R5: only 0 requests -> wrap to 0
    init_cyc = 3'b001;
    step();
    chk_owner(0, "R5");
    init_cyc = '0;
    step();

    // constrained random traffic against the reference model
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom % 6 == 0) init_cyc[i] = ~init_cyc[i];
        init_stb[i]  = ($urandom % 4) != 0;
        init_lock[i] = ($urandom % 5) == 0;
        init_we[i]   = $urandom % 2;
        init_adr[i*AW +: AW]   = AW'($urandom);
        init_dat_w[i*DW +: DW] = DW'($urandom);
        init_sel[i*IS +: IS]   = IS'($urandom);
      end
      bus_ack   = ($urandom % 3) == 0;
      bus_err   = !bus_ack && (($urandom % 12) == 0);
      bus_rty   = !bus_ack && !bus_err && (($urandom % 12) == 0);
      bus_dat_r = DW'($urandom);
      step();
    end

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule